// File: doc/BRIEF.md
# Burst-Capable Bus Target with Self-Generated Data-Phase Addresses

This block is the target side of a simplified 32-bit multiplexed PCI-style bus. It answers single-word and burst memory reads and writes that fall inside one aligned address window. It samples the start address and the command when a transaction opens. It claims the cycle and then drives the target handshake. The initiator never states how many words a burst carries. For that reason the target keeps its own word pointer, advances it after each completed data phase, and spots the final phase from the initiator's handshake.

Each completed data phase turns into one strobe on a local register-file port. Writes carry the bus data and the per-lane byte enables. Reads return data combinationally from the register file and place it on the bus. The bidirectional bus is split into an input, an output and an output enable, so the pad ring owns the tri-state driver. A separate flag reports when all four control lines are inactive, which is the bus-idle condition.

Top module: `pci_burst_target`

## Requirements
- R1: During and after reset, with `frame_n` and `irdy_n` high, `trdy_n` and `devsel_n` are high, `ad_oe` is low and `bus_idle` is high.
- R2: A transaction starts on a clock where `frame_n` is low, provided the clock before it was bus-idle. It is claimed when `ad_i[31:WORD_BITS+2]` matches the window base and `cbe_n` is 4'b0110 (memory read) or 4'b0111 (memory write). `devsel_n` and `trdy_n` then go low together in the second clock after that address clock.
- R3: A transaction whose address is outside the window, or whose command is any other code, is never claimed. The target stays silent until `frame_n` and `irdy_n` are both high.
- R4: A data transfer happens only on a rising edge where `irdy_n` and `trdy_n` are both low. On any other clock the local strobes are low and `lcl_addr` holds.
- R5: `lcl_addr` starts at `ad_i[WORD_BITS+1:2]` of the address clock. It advances by one word (4 bytes) after each transfer, wrapping modulo the window size.
- R6: On a write transfer, `lcl_we` is high with `lcl_wdata` = `ad_i` and `lcl_be` = ~`cbe_n` (bit n enables byte lane n). `lcl_we` and `lcl_re` are never high together.
- R7: On a read, `ad_oe` rises together with `devsel_n` falling, which leaves one turnaround clock after the address clock. `ad_o` carries `lcl_rdata` while `ad_oe` is high and zero otherwise. `lcl_re` marks each read transfer.
- R8: A transfer with `frame_n` high is the last. In the following clock `trdy_n` and `devsel_n` are high and `ad_oe` is low.
- R9: `bus_idle` is high exactly when `frame_n`, `irdy_n`, `trdy_n` and `devsel_n` are all high.
- R10: A `frame_n` assertion in the clock straight after a last transfer, with no idle clock between, is not claimed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Initiator transaction frame, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| ad_i | input | 32 | Address/data bus as seen at the pad |
| cbe_n | input | 4 | Command on the address clock, active-low byte enables on data clocks |
| trdy_n | output | 1 | Target ready, active low |
| devsel_n | output | 1 | Device claim, active low |
| ad_o | output | 32 | Read data toward the pad |
| ad_oe | output | 1 | Output enable for `ad_o` |
| bus_idle | output | 1 | All four control lines inactive |
| lcl_addr | output | WORD_BITS | Word index into the local register file |
| lcl_we | output | 1 | Local write strobe |
| lcl_be | output | 4 | Local write byte-lane enables |
| lcl_wdata | output | 32 | Local write data |
| lcl_re | output | 1 | Local read strobe |
| lcl_rdata | input | 32 | Local read data, combinational from `lcl_addr` |

## Verification
The hardest state to reach is a burst where the initiator withholds ready in the middle of the burst. The pointer must then hold across the wait and resume without skipping or repeating a word. A close second is a new frame arriving in the very clock after a last transfer. The stimulus reaches both on purpose. Burst tasks insert a run of deasserted-ready clocks before a chosen phase, and one burst starts at the top word so that the pointer wraps. A variant of the write task omits the idle tail and opens the next address phase at once. A behavioural model built from counters and an array follows every clock, so a held or skipped pointer shows up as a wrong local address or a wrong read word.

// File: rtl/pbt_pkg.sv
package pbt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TURN = 2'd1,
    ST_DATA = 2'd2,
    ST_SKIP = 2'd3
  } pbt_state_e;

  localparam logic [3:0] CMD_MEM_RD = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR = 4'b0111;

  function automatic logic is_mem_cmd(input logic [3:0] cmd);
    return (cmd == CMD_MEM_RD) || (cmd == CMD_MEM_WR);
  endfunction

  function automatic logic [3:0] lanes_from_cbe(input logic [3:0] cbe_n);
    return ~cbe_n;
  endfunction

endpackage

// File: rtl/pbt_decode.sv
module pbt_decode #(
  parameter logic [31:0] BASE_ADDR = 32'h8000_0000,
  parameter int unsigned WORD_BITS = 4
) (
  input  logic [31:0]          ad,
  input  logic [3:0]           cbe_n,
  output logic                 hit,
  output logic                 is_read,
  output logic [WORD_BITS-1:0] start_word
);
  import pbt_pkg::*;

  localparam int unsigned LSB = WORD_BITS + 2;

  logic win_match;
  logic [1:0] unused_lo;

  assign unused_lo  = ad[1:0];
  assign win_match  = (ad[31:LSB] == BASE_ADDR[31:LSB]);
  assign hit        = win_match && is_mem_cmd(cbe_n);
  assign is_read    = (cbe_n == CMD_MEM_RD);
  assign start_word = ad[LSB-1:2];

endmodule

// File: rtl/pbt_addr_gen.sv
module pbt_addr_gen #(
  parameter int unsigned WORD_BITS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [WORD_BITS-1:0] load_word,
  input  logic                 advance,
  output logic [WORD_BITS-1:0] word
);

  function automatic logic [WORD_BITS-1:0] step(input logic [WORD_BITS-1:0] w);
    return w + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word <= '0;
    end else if (load) begin
      word <= load_word;
    end else if (advance) begin
      word <= step(word);
    end
  end

endmodule

// File: rtl/pbt_fsm.sv
module pbt_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_n,
  input  logic irdy_n,
  input  logic hit,
  input  logic is_read,
  output logic trdy_n,
  output logic devsel_n,
  output logic ad_oe,
  output logic bus_idle,
  output logic start,
  output logic xfer,
  output logic last,
  output logic read_q
);
  import pbt_pkg::*;

  pbt_state_e state_q, state_d;
  logic       idle_q;

  assign bus_idle = frame_n && irdy_n && trdy_n && devsel_n;
  assign start    = (state_q == ST_IDLE) && !frame_n && idle_q;
  assign xfer     = (state_q == ST_DATA) && !irdy_n && !trdy_n;
  assign last     = xfer && frame_n;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start) state_d = hit ? ST_TURN : ST_SKIP;
      ST_TURN: state_d = ST_DATA;
      ST_DATA: if (last) state_d = ST_IDLE;
      ST_SKIP: if (frame_n && irdy_n) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      trdy_n   <= 1'b1;
      devsel_n <= 1'b1;
      ad_oe    <= 1'b0;
      idle_q   <= 1'b0;
      read_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      trdy_n   <= (state_d != ST_DATA);
      devsel_n <= (state_d != ST_DATA);
      ad_oe    <= (state_d == ST_DATA) && read_q;
      idle_q   <= bus_idle;
      if (start) read_q <= is_read;
    end
  end

endmodule

// File: rtl/pci_burst_target.sv
module pci_burst_target #(
  parameter logic [31:0] BASE_ADDR = 32'h8000_0000,
  parameter int unsigned WORD_BITS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_n,
  input  logic                 irdy_n,
  input  logic [31:0]          ad_i,
  input  logic [3:0]           cbe_n,
  output logic                 trdy_n,
  output logic                 devsel_n,
  output logic [31:0]          ad_o,
  output logic                 ad_oe,
  output logic                 bus_idle,
  output logic [WORD_BITS-1:0] lcl_addr,
  output logic                 lcl_we,
  output logic [3:0]           lcl_be,
  output logic [31:0]          lcl_wdata,
  output logic                 lcl_re,
  input  logic [31:0]          lcl_rdata
);
  import pbt_pkg::*;

  logic                 dec_hit;
  logic                 dec_read;
  logic [WORD_BITS-1:0] dec_word;
  logic                 ev_start;
  logic                 ev_xfer;
  logic                 ev_last;
  logic                 rd_txn;
  logic                 unused_last;

  pbt_decode #(.BASE_ADDR(BASE_ADDR), .WORD_BITS(WORD_BITS)) i_decode (
    .ad(ad_i), .cbe_n(cbe_n), .hit(dec_hit), .is_read(dec_read), .start_word(dec_word)
  );

  pbt_fsm i_fsm (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
    .hit(dec_hit), .is_read(dec_read),
    .trdy_n(trdy_n), .devsel_n(devsel_n), .ad_oe(ad_oe), .bus_idle(bus_idle),
    .start(ev_start), .xfer(ev_xfer), .last(ev_last), .read_q(rd_txn)
  );

  pbt_addr_gen #(.WORD_BITS(WORD_BITS)) i_addr (
    .clk(clk), .rst_n(rst_n), .load(ev_start), .load_word(dec_word),
    .advance(ev_xfer), .word(lcl_addr)
  );

  assign unused_last = ev_last;
  assign lcl_we      = ev_xfer && !rd_txn;
  assign lcl_re      = ev_xfer && rd_txn;
  assign lcl_wdata   = ad_i;
  assign lcl_be      = lanes_from_cbe(cbe_n);
  assign ad_o        = ad_oe ? lcl_rdata : 32'h0;

endmodule

// File: rtl/pbt_checker.sv
module pbt_checker #(
  parameter int unsigned WORD_BITS = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 frame_n,
  input logic                 irdy_n,
  input logic                 trdy_n,
  input logic                 devsel_n,
  input logic                 ad_oe,
  input logic [WORD_BITS-1:0] lcl_addr,
  input logic                 lcl_we,
  input logic                 lcl_re
);

  a_r4_wait_holds_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (!trdy_n && irdy_n) |=> $stable(lcl_addr));

  a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!trdy_n && !irdy_n && !frame_n) |=> (lcl_addr == WORD_BITS'($past(lcl_addr) + 1'b1)));

  a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!trdy_n && !irdy_n && frame_n) |=> (trdy_n && devsel_n && !ad_oe));

  a_r6_strobe_handshake: assert property (@(posedge clk) disable iff (!rst_n)
    (lcl_we || lcl_re) |-> (!irdy_n && !trdy_n));

  a_r6_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lcl_we, lcl_re}));

  a_r7_oe_claimed: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> !devsel_n);

  a_r2_claim_delay: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(devsel_n) |-> $past(!frame_n, 2));

endmodule

bind pci_burst_target pbt_checker #(.WORD_BITS(WORD_BITS)) i_pbt_checker (
  .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
  .trdy_n(trdy_n), .devsel_n(devsel_n), .ad_oe(ad_oe),
  .lcl_addr(lcl_addr), .lcl_we(lcl_we), .lcl_re(lcl_re)
);

// File: tb/test_pci_burst_target.sv
module test_pci_burst_target;

  localparam logic [31:0] BASE = 32'h8000_0000;
  localparam int WB    = 4;
  localparam int WORDS = 1 << WB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_n = 1'b1, irdy_n = 1'b1;
  logic [31:0] ad_i = '0;
  logic [3:0]  cbe_n = 4'hF;
  logic trdy_n, devsel_n, ad_oe, bus_idle, lcl_we, lcl_re;
  logic [31:0] ad_o, lcl_wdata, lcl_rdata;
  logic [3:0]  lcl_be;
  logic [WB-1:0] lcl_addr;

  logic [31:0] mem     [WORDS];
  logic [31:0] ref_mem [WORDS];

  int compared = 0, mismatched = 0, cycles = 0, seq = 0;

  // model state
  int m_phase = 0;   // 0 idle, 1 turnaround, 2 data, 3 unclaimed
  int m_addr  = 0;
  bit m_read  = 0;
  bit m_idle_prev = 0;

  always #5 clk = ~clk;

  pci_burst_target #(.BASE_ADDR(BASE), .WORD_BITS(WB)) i_pci_burst_target (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n), .ad_i(ad_i),
    .cbe_n(cbe_n), .trdy_n(trdy_n), .devsel_n(devsel_n), .ad_o(ad_o), .ad_oe(ad_oe),
    .bus_idle(bus_idle), .lcl_addr(lcl_addr), .lcl_we(lcl_we), .lcl_be(lcl_be),
    .lcl_wdata(lcl_wdata), .lcl_re(lcl_re), .lcl_rdata(lcl_rdata)
  );

  assign lcl_rdata = mem[lcl_addr];

  always @(posedge clk) begin
    if (lcl_we)
      for (int b = 0; b < 4; b++) if (lcl_be[b]) mem[lcl_addr][8*b +: 8] <= lcl_wdata[8*b +: 8];
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model: advance at each rising edge
  always @(posedge clk) begin
    bit xf, idle_now;
    if (!rst_n) begin
      m_phase = 0; m_idle_prev = 0;
    end else begin
      xf = (m_phase == 2) && !irdy_n;
      idle_now = frame_n && irdy_n && (m_phase != 2);
      case (m_phase)
        0: if (!frame_n && m_idle_prev) begin
             if (ad_i[31:WB+2] == BASE[31:WB+2] && (cbe_n == 4'b0110 || cbe_n == 4'b0111)) begin
               m_phase = 1; m_addr = int'(ad_i[WB+1:2]); m_read = (cbe_n == 4'b0110);
             end else m_phase = 3;
           end
        1: m_phase = 2;
        2: if (xf) begin
             if (!m_read)
               for (int b = 0; b < 4; b++) if (!cbe_n[b]) ref_mem[m_addr][8*b +: 8] = ad_i[8*b +: 8];
             m_addr = (m_addr + 1) % WORDS;
             if (frame_n) m_phase = 0;
           end
        3: if (frame_n && irdy_n) m_phase = 0;
        default: m_phase = 0;
      endcase
      m_idle_prev = idle_now;
    end
  end

  // compare every clock, away from the edge
  always @(negedge clk) begin
    bit claimed, xf;
    #2;
    if (rst_n) begin
      claimed = (m_phase == 2);
      xf = claimed && !irdy_n;
      chk(m_phase == 3 ? "R3/R10 devsel_n" : "R2 devsel_n", {31'b0, devsel_n}, {31'b0, !claimed});
      chk("R2 trdy_n", {31'b0, trdy_n}, {31'b0, !claimed});
      chk("R7 ad_oe", {31'b0, ad_oe}, {31'b0, claimed && m_read});
      chk("R7 ad_o", ad_o, (claimed && m_read) ? ref_mem[m_addr] : 32'h0);
      chk("R9 bus_idle", {31'b0, bus_idle}, {31'b0, frame_n && irdy_n && !claimed});
      chk("R4/R6 lcl_we", {31'b0, lcl_we}, {31'b0, xf && !m_read});
      chk("R4/R7 lcl_re", {31'b0, lcl_re}, {31'b0, xf && m_read});
      if (claimed) chk("R5 lcl_addr", {28'b0, lcl_addr}, m_addr);
      if (xf && !m_read) begin
        chk("R6 lcl_wdata", lcl_wdata, ad_i);
        chk("R6 lcl_be", {28'b0, lcl_be}, {28'b0, ~cbe_n});
      end
    end
  end

  task automatic drv(input logic f, input logic i, input logic [31:0] a, input logic [3:0] c);
    @(negedge clk);
    frame_n = f; irdy_n = i; ad_i = a; cbe_n = c;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) drv(1'b1, 1'b1, 32'h0, 4'hF);
  endtask

  task automatic txn(input bit wr, input int w0, input int n, input int wait_at,
                     input int wait_len, input logic [3:0] be_n, input bit tail);
    drv(1'b0, 1'b1, BASE + 32'(w0 * 4), wr ? 4'b0111 : 4'b0110);
    for (int k = 0; k < n; k++) begin
      logic [31:0] d;
      d = 32'hA500_0000 + 32'(seq);
      seq++;
      if (k == wait_at)
        for (int j = 0; j < wait_len; j++) drv(1'b0, 1'b1, 32'h0, be_n);
      do begin
        drv(k == n - 1, 1'b0, wr ? d : 32'h0, wr ? be_n : 4'h0);
        #1;
      end while (trdy_n);
    end
    if (tail) begin
      drv(1'b1, 1'b1, 32'h0, 4'hF);
      #1;
      chk("R8 trdy_n after last", {31'b0, trdy_n}, 32'd1);
      chk("R8 devsel_n after last", {31'b0, devsel_n}, 32'd1);
      chk("R8 ad_oe after last", {31'b0, ad_oe}, 32'd0);
    end
  endtask

  task automatic unclaimed(input logic [31:0] a, input logic [3:0] cmd);
    drv(1'b0, 1'b1, a, cmd);
    for (int k = 0; k < 3; k++) begin
      drv(1'b1, 1'b0, 32'h0, 4'h0);
      #1;
      chk("R3 no claim", {31'b0, devsel_n}, 32'd1);
    end
    drv(1'b1, 1'b1, 32'h0, 4'hF);
  endtask

  initial begin
    for (int k = 0; k < WORDS; k++) begin
      mem[k] = 32'hC0DE_0000 + 32'(k);
      ref_mem[k] = mem[k];
    end
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset trdy_n", {31'b0, trdy_n}, 32'd1);
    chk("R1 reset devsel_n", {31'b0, devsel_n}, 32'd1);
    chk("R1 reset ad_oe", {31'b0, ad_oe}, 32'd0);
    chk("R1 reset bus_idle", {31'b0, bus_idle}, 32'd1);
    rst_n = 1'b1;
    idle(2);

    txn(1, 3, 1, -1, 0, 4'h0, 1); idle(1);          // single write
    txn(0, 3, 1, -1, 0, 4'h0, 1); idle(1);          // single read
    txn(1, 5, 4, 2, 3, 4'b1010, 1); idle(2);        // burst write, wait mid-burst, partial lanes
    txn(0, 4, 5, 1, 2, 4'h0, 1); idle(1);           // burst read with waits
    txn(1, 15, 2, -1, 0, 4'h0, 1); idle(1);         // R5 wrap at top word
    txn(0, 14, 4, 3, 1, 4'h0, 1); idle(1);          // read across wrap
    txn(1, 0, 2, -1, 0, 4'h0, 1); idle(1);          // back-to-back, one idle clock
    txn(0, 0, 2, 0, 2, 4'h0, 1); idle(1);
    unclaimed(32'h4000_0000, 4'b0111); idle(1);     // R3 outside window
    unclaimed(BASE, 4'b0010); idle(1);              // R3 non-memory command
    txn(1, 8, 1, -1, 0, 4'h0, 0);                   // R10 no idle before next frame
    unclaimed(BASE + 32'h20, 4'b0110); idle(2);
    txn(0, 8, 1, -1, 0, 4'h0, 1); idle(2);
    txn(0, 5, 4, -1, 0, 4'h0, 1); idle(2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      compared++; mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule